// File: doc/BRIEF.md
# DRAM Precharge-Residency Statistics Monitor

This block sits beside a DRAM controller and turns its command events into the raw counters needed for an offline power estimate. The controller reports, one pulse per cycle, row activates, precharges forced by a row conflict, accesses that finish under closed-page policy, and refreshes. Each pulse carries a timestamp. A two-bit page-policy select tells the monitor how the controller manages rows.

From these events the monitor tracks the number of banks holding an open row and the time at which every bank last became precharged. When an activate arrives with no bank open, it adds the gap since that moment to a running total. That total is the time the whole device sat idle with all banks precharged. The monitor also counts bytes read from the array and bytes forwarded from the write queue, along with request and row-hit counts, so software can later form hit ratios and bus utilisation. Percentages are not computed here.

Top module: `dram_idle_residency_mon`

## Requirements
- R1: After reset every counter output, `start_time`, `idle_total`, `active_banks` and `underflow_err` read zero.
- R2: An activate raises `active_banks` by one only when `policy` is 1 (open) or 2 (open-adaptive), and never above NBANK. Under 0 (closed), and under 3, which is treated as closed, the count is unchanged.
- R3: On an activate that sees `active_banks` at zero and `act_time` strictly greater than `start_time`, `idle_total` grows by `act_time - start_time`. Otherwise `idle_total` is unchanged.
- R4: A conflict precharge (`pre_vld`) lowers `active_banks` by one. When the count reaches zero, `start_time` becomes the larger of itself and `pre_ready`.
- R5: Under closed policy, `cls_vld` sets `start_time` to the larger of itself and `cls_ready`. Under open policies `cls_vld` has no effect.
- R6: A refresh clears `active_banks`. It sets `start_time` to the larger of `ref_now` and `ref_max_free`, plus TRFC.
- R7: Events in the same cycle apply in a fixed order: refresh, then precharge, then closed-page access, then activate.
- R8: `bytes_rd_dram` grows by BURST_BYTES on each `rd_dram_vld`. `bytes_rd_wrq` grows by BURST_BYTES on each `rd_wrq_vld`.
- R9: `rd_reqs`, `wr_reqs`, `rd_hits` and `wr_hits` each count one per pulse on their own input. `wrq_served` counts `rd_wrq_vld` pulses.
- R10: A precharge that sees `active_banks` at zero leaves the count at zero and sets `underflow_err`. The flag then stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy | input | 2 | Page policy: 0 closed, 1 open, 2 open-adaptive, 3 closed |
| act_vld | input | 1 | Row activate event |
| act_time | input | TW | Activate timestamp |
| pre_vld | input | 1 | Conflict precharge event |
| pre_ready | input | TW | Ready time of the precharged bank |
| cls_vld | input | 1 | Closed-page access completed |
| cls_ready | input | TW | Ready time of the accessed bank |
| ref_vld | input | 1 | Refresh event |
| ref_now | input | TW | Current time at refresh |
| ref_max_free | input | TW | Latest bank-free time at refresh |
| rd_dram_vld | input | 1 | Read burst returned from the array |
| rd_wrq_vld | input | 1 | Read burst served from the write queue |
| rd_req | input | 1 | Read request accepted |
| wr_req | input | 1 | Write request accepted |
| rd_hit | input | 1 | Read row hit |
| wr_hit | input | 1 | Write row hit |
| active_banks | output | AW | Banks holding an open row |
| start_time | output | TW | Time at which all banks became precharged |
| idle_total | output | TW | Accumulated all-precharged time |
| bytes_rd_dram | output | CW | Bytes read from the array |
| bytes_rd_wrq | output | CW | Bytes read from the write queue |
| rd_reqs | output | CW | Read request count |
| wr_reqs | output | CW | Write request count |
| rd_hits | output | CW | Read row-hit count |
| wr_hits | output | CW | Write row-hit count |
| wrq_served | output | CW | Reads served by the write queue |
| underflow_err | output | 1 | Sticky underflow of the active-bank count |

## Verification
Every piece of state is also an output, so a wrong active-bank count or start time appears on `active_banks` or `start_time` one cycle after the event that corrupted it. Its effect on `idle_total` appears only at the next activate that finds the count at zero, and that can be many events later. The bench therefore compares all outputs after every cycle, so that a fault is blamed on the cycle that caused it and not on the later accumulation.

// File: rtl/dram_idle_residency_mon.sv
module dram_idle_residency_mon #(
  parameter int TW          = 48,
  parameter int CW          = 32,
  parameter int NBANK       = 16,
  parameter int TRFC        = 64,
  parameter int BURST_BYTES = 64,
  localparam int AW         = $clog2(NBANK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    policy,
  input  logic          act_vld,
  input  logic [TW-1:0] act_time,
  input  logic          pre_vld,
  input  logic [TW-1:0] pre_ready,
  input  logic          cls_vld,
  input  logic [TW-1:0] cls_ready,
  input  logic          ref_vld,
  input  logic [TW-1:0] ref_now,
  input  logic [TW-1:0] ref_max_free,
  input  logic          rd_dram_vld,
  input  logic          rd_wrq_vld,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          rd_hit,
  input  logic          wr_hit,
  output logic [AW-1:0] active_banks,
  output logic [TW-1:0] start_time,
  output logic [TW-1:0] idle_total,
  output logic [CW-1:0] bytes_rd_dram,
  output logic [CW-1:0] bytes_rd_wrq,
  output logic [CW-1:0] rd_reqs,
  output logic [CW-1:0] wr_reqs,
  output logic [CW-1:0] rd_hits,
  output logic [CW-1:0] wr_hits,
  output logic [CW-1:0] wrq_served,
  output logic          underflow_err
);

  logic          open_pol;
  logic [AW-1:0] cnt_d;
  logic [TW-1:0] st_d, acc_d;
  logic          err_d;

  assign open_pol = (policy == 2'd1) || (policy == 2'd2);

  always_comb begin
    cnt_d = active_banks;
    st_d  = start_time;
    acc_d = idle_total;
    err_d = underflow_err;
    if (ref_vld) begin
      cnt_d = '0;
      st_d  = ((ref_now > ref_max_free) ? ref_now : ref_max_free) + TW'(TRFC);
    end
    if (pre_vld) begin
      if (cnt_d == '0) begin
        err_d = 1'b1;
      end else begin
        cnt_d = cnt_d - 1'b1;
        if (cnt_d == '0 && pre_ready > st_d) st_d = pre_ready;
      end
    end
    if (cls_vld && !open_pol && cls_ready > st_d) st_d = cls_ready;
    if (act_vld) begin
      if (cnt_d == '0 && act_time > st_d) acc_d = acc_d + (act_time - st_d);
      if (open_pol && cnt_d != AW'(NBANK)) cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_banks  <= '0;
      start_time    <= '0;
      idle_total    <= '0;
      underflow_err <= 1'b0;
      bytes_rd_dram <= '0;
      bytes_rd_wrq  <= '0;
      rd_reqs       <= '0;
      wr_reqs       <= '0;
      rd_hits       <= '0;
      wr_hits       <= '0;
      wrq_served    <= '0;
    end else begin
      active_banks  <= cnt_d;
      start_time    <= st_d;
      idle_total    <= acc_d;
      underflow_err <= err_d;
      if (rd_dram_vld) bytes_rd_dram <= bytes_rd_dram + CW'(BURST_BYTES);
      if (rd_wrq_vld) begin
        bytes_rd_wrq <= bytes_rd_wrq + CW'(BURST_BYTES);
        wrq_served   <= wrq_served + 1'b1;
      end
      if (rd_req) rd_reqs <= rd_reqs + 1'b1;
      if (wr_req) wr_reqs <= wr_reqs + 1'b1;
      if (rd_hit) rd_hits <= rd_hits + 1'b1;
      if (wr_hit) wr_hits <= wr_hits + 1'b1;
    end
  end

  AST_CLOSED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_pol && !ref_vld && !pre_vld) |=> $stable(active_banks)); // R2
  AST_NO_CNT_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    active_banks <= AW'(NBANK)); // R2
  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act_vld && !ref_vld && !pre_vld && !cls_vld && active_banks == '0 && act_time > start_time)
    |=> idle_total == $past(idle_total) + ($past(act_time) - $past(start_time))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !act_vld |=> $stable(idle_total)); // R3
  AST_REF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_vld && !(act_vld && open_pol)) |=> active_banks == '0); // R6
  AST_REF_START: assert property (@(posedge clk) disable iff (!rst_n)
    ref_vld |=> start_time >= $past(ref_now) + TW'(TRFC)); // R6
  AST_DRAM_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dram_vld |=> bytes_rd_dram == $past(bytes_rd_dram) + CW'(BURST_BYTES)); // R8
  AST_ERR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_vld && !ref_vld && active_banks == '0) |=> (underflow_err && active_banks <= AW'(1))); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |=> underflow_err); // R10

endmodule

// File: tb/sim_dram_idle_residency_mon.sv
module sim_dram_idle_residency_mon;
  localparam int TW = 48, CW = 32, NBANK = 16, TRFC = 64, BB = 64;
  localparam int AW = $clog2(NBANK + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] policy;
  logic act_vld, pre_vld, cls_vld, ref_vld;
  logic [TW-1:0] act_time, pre_ready, cls_ready, ref_now, ref_max_free;
  logic rd_dram_vld, rd_wrq_vld, rd_req, wr_req, rd_hit, wr_hit;
  logic [AW-1:0] active_banks;
  logic [TW-1:0] start_time, idle_total;
  logic [CW-1:0] bytes_rd_dram, bytes_rd_wrq, rd_reqs, wr_reqs, rd_hits, wr_hits, wrq_served;
  logic underflow_err;

  dram_idle_residency_mon #(.TW(TW), .CW(CW), .NBANK(NBANK), .TRFC(TRFC), .BURST_BYTES(BB)) u0 (.*);

  typedef struct packed {
    logic [63:0] cnt, st, acc, bd, bw, rq, wq, rh, wh, ws, err;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_run = 0, n_fail = 0;
  exp_t  m;

  task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] ex);
    n_run++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, ex);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, "active_banks",  64'(active_banks),  e.cnt);
      chk(t, "start_time",    64'(start_time),    e.st);
      chk(t, "idle_total",    64'(idle_total),    e.acc);
      chk(t, "bytes_rd_dram", 64'(bytes_rd_dram), e.bd);
      chk(t, "bytes_rd_wrq",  64'(bytes_rd_wrq),  e.bw);
      chk(t, "rd_reqs",       64'(rd_reqs),       e.rq);
      chk(t, "wr_reqs",       64'(wr_reqs),       e.wq);
      chk(t, "rd_hits",       64'(rd_hits),       e.rh);
      chk(t, "wr_hits",       64'(wr_hits),       e.wh);
      chk(t, "wrq_served",    64'(wrq_served),    e.ws);
      chk(t, "underflow_err", 64'(underflow_err), e.err);
    end
  end

  task automatic begin_cyc(logic [1:0] pol);
    @(negedge clk);
    policy = pol;
    act_vld = 0; pre_vld = 0; cls_vld = 0; ref_vld = 0;
    act_time = 0; pre_ready = 0; cls_ready = 0; ref_now = 0; ref_max_free = 0;
    rd_dram_vld = 0; rd_wrq_vld = 0; rd_req = 0; wr_req = 0; rd_hit = 0; wr_hit = 0;
  endtask

  task automatic end_cyc(string tag);
    logic is_open;
    is_open = (policy == 2'd1) || (policy == 2'd2);
    if (ref_vld) begin
      m.cnt = 0;
      m.st  = 64'(ref_now > ref_max_free ? ref_now : ref_max_free) + TRFC;
    end
    if (pre_vld) begin
      if (m.cnt == 0) m.err = 1;
      else begin
        m.cnt = m.cnt - 1;
        if (m.cnt == 0 && 64'(pre_ready) > m.st) m.st = 64'(pre_ready);
      end
    end
    if (cls_vld && !is_open && 64'(cls_ready) > m.st) m.st = 64'(cls_ready);
    if (act_vld) begin
      if (m.cnt == 0 && 64'(act_time) > m.st) m.acc = m.acc + 64'(act_time) - m.st;
      if (is_open && m.cnt < NBANK) m.cnt = m.cnt + 1;
    end
    if (rd_dram_vld) m.bd = m.bd + BB;
    if (rd_wrq_vld) begin m.bw = m.bw + BB; m.ws = m.ws + 1; end
    if (rd_req) m.rq++;
    if (wr_req) m.wq++;
    if (rd_hit) m.rh++;
    if (wr_hit) m.wh++;
    @(posedge clk);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic act(logic [1:0] pol, int t, string tag);
    begin_cyc(pol); act_vld = 1; act_time = TW'(t); end_cyc(tag);
  endtask
  task automatic pre(int r, string tag);
    begin_cyc(2'd1); pre_vld = 1; pre_ready = TW'(r); end_cyc(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m = '0;
    begin_cyc(2'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    begin_cyc(2'd1); end_cyc("R1");
    act(2'd1, 100, "R3");
    act(2'd1, 150, "R2");
    pre(300, "R4");
    pre(400, "R4");
    act(2'd1, 350, "R3");
    pre(380, "R4");
    act(2'd1, 400, "R3");
    pre(500, "R4");
    act(2'd1, 520, "R3");
    begin_cyc(2'd1); ref_vld = 1; ref_now = 600; ref_max_free = 550; end_cyc("R6");
    begin_cyc(2'd1); ref_vld = 1; ref_now = 700; ref_max_free = 800;
    act_vld = 1; act_time = 900; end_cyc("R7");
    begin_cyc(2'd1); pre_vld = 1; pre_ready = 900; act_vld = 1; act_time = 1000; end_cyc("R7");
    act(2'd2, 1100, "R2");
    act(2'd0, 1200, "R2");
    begin_cyc(2'd0); cls_vld = 1; cls_ready = 1300; end_cyc("R5");
    begin_cyc(2'd0); cls_vld = 1; cls_ready = 1250; end_cyc("R5");
    begin_cyc(2'd1); cls_vld = 1; cls_ready = 5000; end_cyc("R5");
    begin_cyc(2'd1); ref_vld = 1; ref_now = 1400; ref_max_free = 1000; end_cyc("R6");
    pre(2000, "R10");
    begin_cyc(2'd1); end_cyc("R10");
    act(2'd0, 1500, "R3");
    act(2'd3, 1600, "R2");
    for (int i = 0; i < 18; i++) act(2'd1, 1700 + i, "R2");
    begin_cyc(2'd1); rd_dram_vld = 1; rd_req = 1; rd_hit = 1; end_cyc("R8");
    begin_cyc(2'd1); rd_wrq_vld = 1; rd_req = 1; end_cyc("R9");
    begin_cyc(2'd1); rd_dram_vld = 1; rd_wrq_vld = 1; wr_req = 1; wr_hit = 1; end_cyc("R8");
    begin_cyc(2'd1); wr_req = 1; end_cyc("R9");
    begin_cyc(2'd1); end_cyc("R9");
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule